// File: doc/BRIEF.md
# Two-Core-Per-Bit Word Memory Controller

This block models a small word-organised store in which every bit is held by a pair of magnetic cores, and runs the cycles that read and write it. A stored one leaves the first core of the pair set and a stored zero leaves the second core set. Reading drives the whole word to the cleared state. Each pair that switches gives a sense pulse whose polarity is judged against the matching buffer flip-flop. A positive pulse leaves the flip-flop alone and a negative pulse complements it, so after the strobe the buffer holds the stored word.

A cycle begins with a one-cycle `start` pulse carrying a 2-bit mode and a word address. READ-WRITE reads with strobe and then writes the buffer back. READ only reads and clears. CLEAR-WRITE clears with the strobe suppressed and then writes the buffer. WRITE adds the buffer pattern onto the pairs without clearing them first. Adding a pattern onto a word that was not cleared can leave both cores of a pair set. A later read of such a bit has no defined value, so the block raises a corruption flag instead. The buffer can be loaded from outside while no cycle is running.

Top module: `cpm_pair_mem`

## Requirements
- R1: After reset `done` and `corrupt` are 0, the buffer `buf_q` is 0, and every pair of every word is cleared.
- R2: Mode codes are 00 READ-WRITE, 01 READ, 10 CLEAR-WRITE and 11 WRITE. `done` is high for exactly one cycle. It rises two clock edges after the edge that samples `start` for codes 00 and 10, and one edge after it for codes 01 and 11.
- R3: READ-WRITE leaves the stored word in `buf_q` and writes it back, so repeated READ-WRITE cycles return the same word.
- R4: At strobe, a buffer bit equal to the stored bit is kept and a buffer bit that differs is complemented. The stored word is therefore recovered whether the buffer held all zeros, all ones or any other value before.
- R5: READ (01) loads the stored word into `buf_q` and leaves the word cleared.
- R6: Reading a cleared word produces no sense pulse and leaves `buf_q` unchanged.
- R7: CLEAR-WRITE (10) leaves `buf_q` unchanged and makes the word equal to the buffer value.
- R8: WRITE (11) onto a cleared word stores the buffer value so that a later read returns it without corruption.
- R9: A read of a word in which any pair has both cores set raises `corrupt` at `done`, and `corrupt` holds until the next accepted `start`. Bits whose pairs hold a single set core still read correctly.
- R10: Each accepted `start` clears `corrupt`. WRITE onto a word last cleared by READ does not raise it.
- R11: While a cycle is running, `start` and `buf_load` are ignored.
- R12: `buf_load` in an idle cycle places `buf_in` in `buf_q` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a memory cycle |
| mode | input | 2 | Cycle mode code (see R2) |
| addr | input | 6 | Word address |
| buf_load | input | 1 | Load the buffer from `buf_in` when idle |
| buf_in | input | 19 | External buffer value |
| buf_q | output | 19 | Buffer register |
| done | output | 1 | One-cycle end-of-cycle pulse |
| corrupt | output | 1 | Last read found a pair with both cores set |

## Verification
All 64 addresses are written with distinct, address-derived patterns and then read back with the buffer preset to all zeros, all ones or the complement of the word. These presets separate a buffer that is truly steered by pulse polarity from one that is simply overwritten or left alone. A second READ-WRITE pass, a READ followed by a read of the emptied word, and a CLEAR-WRITE followed by a read-back show which of the modes clear, strobe and rewrite. A deliberate write onto an uncleared word flips only the low byte. That shows whether the flag reacts to the both-set pairs while the single-core bits still read correctly.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    MODE_RDWR = 2'b00,
    MODE_RD   = 2'b01,
    MODE_CLWR = 2'b10,
    MODE_WR   = 2'b11
  } cyc_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SENSE = 2'b01,
    ST_DRIVE = 2'b10,
    ST_FIN   = 2'b11
  } seq_state_t;
endpackage

// File: rtl/cpm_seq.sv
module cpm_seq
  import cpm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_in,
  input  logic [AW-1:0] addr_in,
  output logic          idle,
  output logic          start_take,
  output logic          sense_en,
  output logic          strobe_en,
  output logic          drive_en,
  output logic          done,
  output logic [AW-1:0] addr_q
);
  seq_state_t state_q, state_d;
  cyc_mode_t  mode_q;

  assign idle       = (state_q == ST_IDLE);
  assign start_take = idle && start;
  assign sense_en   = (state_q == ST_SENSE);
  assign strobe_en  = sense_en && (mode_q != MODE_CLWR);
  assign drive_en   = (state_q == ST_DRIVE);
  assign done       = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cyc_mode_t'(mode_in) == MODE_WR) state_d = ST_DRIVE;
          else                                 state_d = ST_SENSE;
        end
      end
      ST_SENSE: begin
        if (mode_q == MODE_RD) state_d = ST_FIN;
        else                   state_d = ST_DRIVE;
      end
      ST_DRIVE: state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RDWR;
      addr_q <= '0;
    end else if (start_take) begin
      mode_q <= cyc_mode_t'(mode_in);
      addr_q <= addr_in;
    end
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |=> $stable(addr_q));
endmodule

// File: rtl/cpm_array.sv
module cpm_array #(
  parameter int WORDS = 64,
  parameter int BITS  = 19,
  parameter int AW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            clr_en,
  input  logic            drv_en,
  input  logic [BITS-1:0] wdata,
  output logic [BITS-1:0] rd_a,
  output logic [BITS-1:0] rd_b
);
  logic [BITS-1:0] core_a [WORDS];
  logic [BITS-1:0] core_b [WORDS];

  assign rd_a = core_a[addr];
  assign rd_b = core_b[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) begin
        core_a[w] <= '0;
        core_b[w] <= '0;
      end
    end else if (clr_en) begin
      core_a[addr] <= '0;
      core_b[addr] <= '0;
    end else if (drv_en) begin
      core_a[addr] <= core_a[addr] | wdata;
      core_b[addr] <= core_b[addr] | ~wdata;
    end
  end

  assert_sense_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((core_a[$past(addr)] | core_b[$past(addr)]) == '0));

  assert_drive_sets_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |=> (&(core_a[$past(addr)] | core_b[$past(addr)])));
endmodule

// File: rtl/cpm_sense.sv
module cpm_sense #(
  parameter int BITS = 19
) (
  input  logic [BITS-1:0] pair_a,
  input  logic [BITS-1:0] pair_b,
  input  logic [BITS-1:0] buf_cur,
  output logic [BITS-1:0] buf_sensed,
  output logic            both_any
);
  logic [BITS-1:0] both_set;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    logic pulse;
    logic neg;
    assign pulse         = pair_a[i] ^ pair_b[i];
    assign neg           = pulse && (pair_a[i] != buf_cur[i]);
    assign both_set[i]   = pair_a[i] & pair_b[i];
    assign buf_sensed[i] = buf_cur[i] ^ neg;
  end

  assign both_any = |both_set;
endmodule

// File: rtl/cpm_pair_mem.sv
module cpm_pair_mem
  import cpm_pkg::*;
#(
  parameter  int WORDS = 64,
  parameter  int BITS  = 19,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   addr,
  input  logic            buf_load,
  input  logic [BITS-1:0] buf_in,
  output logic [BITS-1:0] buf_q,
  output logic            done,
  output logic            corrupt
);
  logic            idle, start_take, sense_en, strobe_en, drive_en;
  logic [AW-1:0]   addr_q;
  logic [BITS-1:0] pair_a, pair_b, buf_sensed, buf_d;
  logic            both_any, corrupt_d;

  cpm_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode), .addr_in(addr),
    .idle(idle), .start_take(start_take), .sense_en(sense_en),
    .strobe_en(strobe_en), .drive_en(drive_en), .done(done), .addr_q(addr_q)
  );

  cpm_array #(.WORDS(WORDS), .BITS(BITS), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .clr_en(sense_en),
    .drv_en(drive_en), .wdata(buf_q), .rd_a(pair_a), .rd_b(pair_b)
  );

  cpm_sense #(.BITS(BITS)) u_sense (
    .pair_a(pair_a), .pair_b(pair_b), .buf_cur(buf_q),
    .buf_sensed(buf_sensed), .both_any(both_any)
  );

  always_comb begin
    buf_d = buf_q;
    if (idle && buf_load) buf_d = buf_in;
    else if (strobe_en)   buf_d = buf_sensed;
  end

  always_comb begin
    corrupt_d = corrupt;
    if (start_take)    corrupt_d = 1'b0;
    else if (sense_en) corrupt_d = both_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      corrupt <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      corrupt <= corrupt_d;
    end
  end

  assert_flag_cleared_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> !corrupt);

  assert_flag_rises_in_sense_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt) |-> $past(sense_en));

  assert_clear_write_keeps_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && cyc_mode_t'(mode) == MODE_CLWR) |=> ##1 $stable(buf_q));
endmodule

// File: tb/cpm_pair_mem_test.sv
module cpm_pair_mem_test;
  localparam int BITS = 19;
  localparam logic [BITS-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n, start, buf_load, done, corrupt;
  logic [1:0] mode;
  logic [5:0] addr;
  logic [BITS-1:0] buf_in, buf_q;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cpm_pair_mem uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr(addr),
    .buf_load(buf_load), .buf_in(buf_in), .buf_q(buf_q),
    .done(done), .corrupt(corrupt)
  );

  function automatic logic [BITS-1:0] pat(input int a);
    logic [31:0] v;
    v = ((a + 1) * 32'h2F3D5) ^ (a << 9) ^ 32'h15;
    return v[BITS-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [BITS-1:0] v);
    @(negedge clk);
    buf_load = 1'b1;
    buf_in   = v;
    @(negedge clk);
    buf_load = 1'b0;
  endtask

  task automatic run(input logic [1:0] m, input int a, output int lat);
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    addr  = a[5:0];
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [BITS-1:0] snap;
    rst_n = 1'b0; start = 1'b0; buf_load = 1'b0; mode = 2'b00; addr = '0; buf_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && corrupt == 1'b0, "R1 flags", {30'd0, done, corrupt}, 0);
    check(buf_q == '0, "R1 buffer", buf_q, 0);

    // R12 / R6 / R1: read of a never-written word leaves the buffer alone
    load(19'h5A5A5);
    check(buf_q == 19'h5A5A5, "R12 load", buf_q, 19'h5A5A5);
    run(2'b01, 7, lat);
    check(lat == 1, "R2 read latency", lat, 1);
    check(buf_q == 19'h5A5A5 && !corrupt, "R6 cleared read", buf_q, 19'h5A5A5);

    // R8: fill every word with WRITE mode
    for (int a = 0; a < 64; a++) begin
      load(pat(a));
      run(2'b11, a, lat);
      if (a == 0) check(lat == 1, "R2 write latency", lat, 1);
      if (corrupt) check(1'b0, "R8 write flag", corrupt, 0);
    end

    // R3 / R4: READ-WRITE sweep with varied buffer presets
    for (int a = 0; a < 64; a++) begin
      logic [BITS-1:0] pre;
      pre = (a % 3 == 0) ? '0 : (a % 3 == 1) ? ONES : ~pat(a);
      load(pre);
      run(2'b00, a, lat);
      if (a == 0) check(lat == 2, "R2 read-write latency", lat, 2);
      check(buf_q == pat(a) && !corrupt, "R4 strobe steering", buf_q, pat(a));
    end
    // R3: second pass returns the rewritten words
    for (int a = 0; a < 64; a += 5) begin
      load(pat(a) ^ 19'h0F0F0);
      run(2'b00, a, lat);
      check(buf_q == pat(a), "R3 rewrite", buf_q, pat(a));
    end

    // R5: READ empties the word
    load('0);
    run(2'b01, 10, lat);
    check(buf_q == pat(10), "R5 read value", buf_q, pat(10));
    load(ONES);
    run(2'b01, 10, lat);
    check(buf_q == ONES && !corrupt, "R5 word cleared", buf_q, ONES);
    // R10: write after READ is legal
    load(19'h3C3C3);
    run(2'b11, 10, lat);
    load('0);
    run(2'b00, 10, lat);
    check(buf_q == 19'h3C3C3 && !corrupt, "R10 write after read", buf_q, 19'h3C3C3);

    // R7: CLEAR-WRITE
    load(19'h12345);
    run(2'b10, 20, lat);
    check(lat == 2, "R2 clear-write latency", lat, 2);
    check(buf_q == 19'h12345, "R7 buffer kept", buf_q, 19'h12345);
    load('0);
    run(2'b00, 20, lat);
    check(buf_q == 19'h12345 && !corrupt, "R7 word written", buf_q, 19'h12345);

    // R9: write onto an uncleared word flips the low byte pairs to both-set
    load(pat(30) ^ 19'h000FF);
    run(2'b11, 30, lat);
    load('0);
    run(2'b00, 30, lat);
    check(corrupt == 1'b1, "R9 flag raised", corrupt, 1);
    check(buf_q[18:8] == pat(30) >> 8, "R9 single-core bits", buf_q[18:8], pat(30) >> 8);
    repeat (3) @(negedge clk);
    check(corrupt == 1'b1, "R9 flag held", corrupt, 1);
    snap = buf_q;
    run(2'b00, 30, lat);
    check(corrupt == 1'b0, "R10 flag cleared", corrupt, 0);
    check(buf_q == snap, "R3 after recovery", buf_q, snap);

    // R11: start and load during a running cycle are ignored
    load('0);
    @(negedge clk);
    start = 1'b1; mode = 2'b00; addr = 6'd40;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = 2'b01; addr = 6'd41; buf_load = 1'b1; buf_in = ONES;
    @(negedge clk);
    start = 1'b0; buf_load = 1'b0;
    check(done == 1'b1, "R11 cycle end", done, 1);
    check(buf_q == pat(40), "R11 load ignored", buf_q, pat(40));
    begin
      int extra;
      extra = 0;
      repeat (4) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R11 no stray cycle", extra, 0);
    end
    load('0);
    run(2'b00, 41, lat);
    check(buf_q == pat(41), "R11 other word untouched", buf_q, pat(41));
    load(ONES);
    run(2'b00, 40, lat);
    check(buf_q == pat(40), "R11 word rewritten", buf_q, pat(40));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule